// File: doc/BRIEF.md
# Double-to-integer truncating converter

The block converts one 64-bit double-precision floating-point value into a signed integer, always rounding toward zero. A caller presents the operand with `in_valid` high, and one clock later the integer result appears together with two status flags: `out_invalid`, for values that cannot be represented, and `out_inexact`, for values that lost a nonzero fraction. When the operand comes from a wider vector register, the caller supplies only its low 64 bits.

Two control inputs choose the result width for each operand. The result is 64 bits wide only when both `long_mode` and `wide_op` are high. In every other case it is 32 bits wide and is placed zero-extended on the low half of `out_data`. An operand that is NaN, infinite or out of range for the chosen width returns the fixed integer-indefinite pattern, which has only the sign bit of the chosen width set.

The single register stage is driven by a two-state machine. State `ST_EMPTY` means no result is held. State `ST_LOADED` means a result is held and `out_valid` is high. Transition `EMPTY_TO_LOADED` occurs on a clock edge with `in_valid` high. `LOADED_TO_LOADED` is a back-to-back operand. `LOADED_TO_EMPTY` occurs when `in_valid` is low. `EMPTY_TO_EMPTY` is an idle cycle. Synchronous reset forces `ST_EMPTY`.

Top module: `dbl2int_trunc`

## Requirements
- R1: A finite in-range operand yields its value truncated toward zero, as a two's-complement integer of the selected width.
- R2: The 64-bit width is used only when `long_mode` and `wide_op` are both 1. Any other combination gives a 32-bit result, including `wide_op`=1 with `long_mode`=0.
- R3: In 32-bit width, a truncated value above 2147483647 or below -2147483648 gives `out_data` = 64'h0000_0000_8000_0000 with `out_invalid`=1 and `out_inexact`=0.
- R4: In 64-bit width, a truncated value outside the signed 64-bit range gives `out_data` = 64'h8000_0000_0000_0000 with `out_invalid`=1. 2^63 is such a value, while the largest double below 2^63 converts normally.
- R5: A NaN operand (exponent field all ones, fraction nonzero, quiet or signaling) or an infinity of either sign gives the indefinite pattern of the selected width, with `out_invalid`=1.
- R6: `out_inexact` is 1 exactly when truncation discards a nonzero fraction and `out_invalid` is 0. The two flags are never both 1.
- R7: Any operand with magnitude below 1 gives `out_data`=0 and `out_invalid`=0. This covers +0, -0, denormals and normals with exponent field below 1023. `out_inexact` is 1 for such an operand only when it is nonzero.
- R8: The most negative integer of the selected width is a legal result. An operand of -2^31, or one in (-2^31-1, -2^31) in 32-bit width, gives 32'h8000_0000 with `out_invalid`=0. -2^63 in 64-bit width gives 64'h8000_0000_0000_0000 with `out_invalid`=0.
- R9: With 32-bit width, bits 63:32 of `out_data` are always 0. This holds for negative results too.
- R10: `out_valid` equals `in_valid` delayed by exactly one clock, and it is 0 on the clock after any cycle with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 64 | Double-precision operand (sign, 11-bit exponent, 52-bit fraction) |
| long_mode | input | 1 | Long-mode qualifier for the wide result |
| wide_op | input | 1 | Wide-operand request for the 64-bit result |
| out_valid | output | 1 | Result registers hold a new result |
| out_data | output | 64 | Signed integer result, zero-extended in 32-bit width |
| out_invalid | output | 1 | Operand was NaN, infinite or out of range |
| out_inexact | output | 1 | A nonzero fraction was discarded |

## Verification
The bound properties relate each result to the operand and mode seen one clock earlier. They therefore assume that `in_data`, `long_mode` and `wide_op` are known whenever `in_valid` is high, and that `rst` is high from time zero. The stimulus holds reset from the start and drives every input on the falling edge with defined values, including the cycles it spends idle. The operand set is chosen around the exact boundaries where behaviour switches: ±2^31, just beyond -2^31, 2^63 and the double just below it, the 2^52 point where the shift changes direction, special encodings, and sub-unit magnitudes.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;

    localparam int FP_EXP_W  = 11;
    localparam int FP_FRAC_W = 52;
    localparam int FP_W      = 1 + FP_EXP_W + FP_FRAC_W;

    // operand class decided from the exponent and fraction fields
    typedef enum logic [2:0] {
        CLS_ZERO,    // +0 or -0
        CLS_TINY,    // nonzero, magnitude below one
        CLS_FINITE,  // integer part fits the widest shifter
        CLS_HUGE,    // magnitude at or above 2^INT_W
        CLS_INF,     // infinity
        CLS_NAN      // quiet or signaling NaN
    } dcls_t;

endpackage

// File: rtl/dbl2int_classify.sv
module dbl2int_classify
    import dbl2int_pkg::*;
#(
    parameter  int EXP_W  = FP_EXP_W,
    parameter  int FRAC_W = FP_FRAC_W,
    parameter  int INT_W  = 64,
    localparam int SH_W   = $clog2(INT_W)
) (
    input  logic [EXP_W+FRAC_W:0] value,
    output logic                  sign,
    output dcls_t                 cls,
    output logic [SH_W-1:0]       shamt,
    output logic [FRAC_W:0]       sig
);

    localparam int               BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_ONES  = '1;
    localparam logic [EXP_W-1:0] EXP_BIAS  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_LIMIT = EXP_W'(BIAS + INT_W);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sign   = value[EXP_W+FRAC_W];
    assign exp_f  = value[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_f = value[FRAC_W-1:0];

    // only consulted for CLS_FINITE, where the hidden bit is always one
    assign sig   = {1'b1, frac_f};
    assign shamt = SH_W'(exp_f - EXP_BIAS);

    always_comb begin
        if (exp_f == EXP_ONES) begin
            cls = (frac_f != '0) ? CLS_NAN : CLS_INF;
        end else if ((exp_f == '0) && (frac_f == '0)) begin
            cls = CLS_ZERO;
        end else if (exp_f < EXP_BIAS) begin
            cls = CLS_TINY;
        end else if (exp_f >= EXP_LIMIT) begin
            cls = CLS_HUGE;
        end else begin
            cls = CLS_FINITE;
        end
    end

endmodule

// File: rtl/dbl2int_shifter.sv
module dbl2int_shifter #(
    parameter  int FRAC_W = 52,
    parameter  int INT_W  = 64,
    localparam int SH_W   = $clog2(INT_W)
) (
    input  logic [FRAC_W:0]   sig,
    input  logic [SH_W-1:0]   shamt,
    output logic [INT_W-1:0]  mag,
    output logic              lost
);

    // fixed-point word: binary point sits just above bit FRAC_W-1
    localparam int FIX_W = FRAC_W + INT_W;

    logic [FIX_W-1:0] stage [SH_W+1];

    assign stage[0] = {{(INT_W-1){1'b0}}, sig};

    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
        end
    endgenerate

    assign mag  = stage[SH_W][FIX_W-1:FRAC_W];
    assign lost = |stage[SH_W][FRAC_W-1:0];

endmodule

// File: rtl/dbl2int_pack.sv
module dbl2int_pack
    import dbl2int_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic              sign,
    input  dcls_t             cls,
    input  logic [INT_W-1:0]  mag,
    input  logic              lost,
    input  logic              wide,
    output logic [INT_W-1:0]  data,
    output logic              invalid,
    output logic              inexact
);

    localparam logic [INT_W-1:0] WIDE_NEG    = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] WIDE_POS    = ~WIDE_NEG;
    localparam logic [INT_W-1:0] NARROW_NEG  = INT_W'(1) << (NARROW_W - 1);
    localparam logic [INT_W-1:0] NARROW_POS  = NARROW_NEG - INT_W'(1);
    localparam logic [INT_W-1:0] NARROW_MASK = (INT_W'(1) << NARROW_W) - INT_W'(1);

    logic [INT_W-1:0] limit;
    logic [INT_W-1:0] twos;
    logic [INT_W-1:0] indef;
    logic             fits;

    // negative side admits one more step of magnitude than the positive side
    assign limit = sign ? (wide ? WIDE_NEG : NARROW_NEG)
                        : (wide ? WIDE_POS : NARROW_POS);
    assign fits  = (mag <= limit);
    assign twos  = sign ? (~mag + INT_W'(1)) : mag;
    assign indef = wide ? WIDE_NEG : NARROW_NEG;

    always_comb begin
        data    = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                data = '0;
            end
            CLS_TINY: begin
                inexact = 1'b1;
            end
            CLS_FINITE: begin
                if (fits) begin
                    data    = wide ? twos : (twos & NARROW_MASK);
                    inexact = lost;
                end else begin
                    data    = indef;
                    invalid = 1'b1;
                end
            end
            CLS_HUGE, CLS_INF, CLS_NAN: begin
                data    = indef;
                invalid = 1'b1;
            end
            default: begin
                data    = indef;
                invalid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dbl2int_trunc.sv
module dbl2int_trunc
    import dbl2int_pkg::*;
#(
    parameter  int EXP_W    = FP_EXP_W,
    parameter  int FRAC_W   = FP_FRAC_W,
    parameter  int INT_W    = 64,
    parameter  int NARROW_W = 32,
    localparam int IN_W     = 1 + EXP_W + FRAC_W,
    localparam int SH_W     = $clog2(INT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             long_mode,
    input  logic             wide_op,
    output logic             out_valid,
    output logic [INT_W-1:0] out_data,
    output logic             out_invalid,
    output logic             out_inexact
);

    typedef enum logic {
        ST_EMPTY,
        ST_LOADED
    } stage_state_t;

    stage_state_t state;
    stage_state_t state_nx;

    logic             op_sign;
    dcls_t            op_cls;
    logic [SH_W-1:0]  op_shamt;
    logic [FRAC_W:0]  op_sig;
    logic [INT_W-1:0] op_mag;
    logic             op_lost;
    logic             op_wide;
    logic [INT_W-1:0] res_data;
    logic             res_invalid;
    logic             res_inexact;

    assign op_wide = long_mode & wide_op;

    dbl2int_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .INT_W  (INT_W)
    ) u_classify (
        .value  (in_data),
        .sign   (op_sign),
        .cls    (op_cls),
        .shamt  (op_shamt),
        .sig    (op_sig)
    );

    dbl2int_shifter #(
        .FRAC_W (FRAC_W),
        .INT_W  (INT_W)
    ) u_shifter (
        .sig    (op_sig),
        .shamt  (op_shamt),
        .mag    (op_mag),
        .lost   (op_lost)
    );

    dbl2int_pack #(
        .INT_W    (INT_W),
        .NARROW_W (NARROW_W)
    ) u_pack (
        .sign     (op_sign),
        .cls      (op_cls),
        .mag      (op_mag),
        .lost     (op_lost),
        .wide     (op_wide),
        .data     (res_data),
        .invalid  (res_invalid),
        .inexact  (res_inexact)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY:  state_nx = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_nx = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_nx = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // result registers, loaded on every accepted operand
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data    <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_data    <= res_data;
            out_invalid <= res_invalid;
            out_inexact <= res_inexact;
        end
    end

    always_comb begin
        out_valid = (state == ST_LOADED);
    end

endmodule

// File: rtl/dbl2int_trunc_chk.sv
module dbl2int_trunc_chk
    import dbl2int_pkg::*;
#(
    parameter  int EXP_W    = FP_EXP_W,
    parameter  int FRAC_W   = FP_FRAC_W,
    parameter  int INT_W    = 64,
    parameter  int NARROW_W = 32,
    localparam int IN_W     = 1 + EXP_W + FRAC_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             long_mode,
    input logic             wide_op,
    input logic             out_valid,
    input logic [INT_W-1:0] out_data,
    input logic             out_invalid,
    input logic             out_inexact
);

    localparam logic [EXP_W-1:0] EXP_BIAS   = EXP_W'((1 << (EXP_W - 1)) - 1);
    localparam logic [INT_W-1:0] WIDE_IND   = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] NARROW_IND = INT_W'(1) << (NARROW_W - 1);

    logic started = 1'b0;

    always_ff @(posedge clk) begin
        started <= 1'b1;
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst || !started)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!started)
        $past(rst) |-> !out_valid);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst || !started)
        out_valid |-> !(out_invalid && out_inexact));

    assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (rst || !started)
        (out_valid && !$past(rst) && !$past(long_mode && wide_op))
        |-> (out_data[INT_W-1:NARROW_W] == '0));

    assert_narrow_indef_R3: assert property (@(posedge clk) disable iff (rst || !started)
        (out_valid && out_invalid && !$past(rst) && !$past(long_mode && wide_op))
        |-> (out_data == NARROW_IND));

    assert_special_indef_R5: assert property (@(posedge clk) disable iff (rst || !started)
        (out_valid && !$past(rst) && $past(&in_data[IN_W-2:FRAC_W]))
        |-> (out_invalid && (out_data == ($past(long_mode && wide_op) ? WIDE_IND : NARROW_IND))));

    assert_tiny_zero_R7: assert property (@(posedge clk) disable iff (rst || !started)
        (out_valid && !$past(rst) && $past(in_data[IN_W-2:FRAC_W] < EXP_BIAS))
        |-> ((out_data == '0) && !out_invalid && (out_inexact == $past(|in_data[IN_W-2:0]))));

endmodule

bind dbl2int_trunc dbl2int_trunc_chk #(
    .EXP_W    (EXP_W),
    .FRAC_W   (FRAC_W),
    .INT_W    (INT_W),
    .NARROW_W (NARROW_W)
) u_chk (.*);

// File: tb/tb_dbl2int_trunc.sv
`timescale 1ns/1ps
module tb_dbl2int_trunc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        long_mode = 1'b0;
    logic        wide_op = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_invalid;
    logic        out_inexact;

    typedef struct {
        logic [63:0] d;
        logic        inv;
        logic        inx;
        string       tag;
    } exp_item_t;

    exp_item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] N_IND = 64'h0000_0000_8000_0000;
    localparam logic [63:0] W_IND = 64'h8000_0000_0000_0000;

    always #4 clk = ~clk;

    dbl2int_trunc dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .long_mode   (long_mode),
        .wide_op     (wide_op),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    task automatic send(input logic [63:0] x, input logic lm, input logic wo,
                        input logic [63:0] ed, input logic ei, input logic ex,
                        input string tag);
        exp_item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = x;
        long_mode = lm;
        wide_op   = wo;
        it.d = ed; it.inv = ei; it.inx = ex; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic gap_check(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: out_valid=%b expected 0", tag, out_valid);
        end
    endtask

    // monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (!rst && out_valid === 1'b1) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected result: data=%h expected none", out_data);
            end else begin
                exp_item_t e;
                e = q.pop_front();
                if (out_data !== e.d || out_invalid !== e.inv || out_inexact !== e.inx) begin
                    errors++;
                    $display("FAIL %s: data=%h inv=%b inx=%b expected data=%h inv=%b inx=%b",
                             e.tag, out_data, out_invalid, out_inexact, e.d, e.inv, e.inx);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset with a pending operand: no result may appear (R10)
        in_valid = 1'b1;
        in_data  = $realtobits(7.0);
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R10 reset: out_valid=%b expected 0", out_valid);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== 64'h0) begin
            errors++;
            $display("FAIL R10 post-reset: out_valid=%b data=%h expected 0 and 0", out_valid, out_data);
        end

        // R1 R9 truncation, narrow width, back-to-back
        send($realtobits(3.75),  1'b0, 1'b0, 64'h0000_0000_0000_0003, 1'b0, 1'b1, "R1 3.75");
        send($realtobits(-3.75), 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFD, 1'b0, 1'b1, "R9 -3.75");
        send($realtobits(42.0),  1'b0, 1'b0, 64'h0000_0000_0000_002A, 1'b0, 1'b0, "R1 42");
        send($realtobits(1.0),   1'b1, 1'b1, 64'h0000_0000_0000_0001, 1'b0, 1'b0, "R1 1.0 wide");
        send($realtobits(2147483647.5), 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, "R1 max32+0.5");
        gap_check("R10 gap");

        // R3 narrow range edges
        send($realtobits(2147483647.0), 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, "R3 2^31-1");
        send($realtobits(2147483648.0), 1'b0, 1'b0, N_IND, 1'b1, 1'b0, "R3 2^31");
        send($realtobits(-2147483649.0), 1'b0, 1'b0, N_IND, 1'b1, 1'b0, "R3 -2^31-1");
        // R8 most negative is legal
        send($realtobits(-2147483648.0), 1'b0, 1'b0, N_IND, 1'b0, 1'b0, "R8 -2^31");
        send($realtobits(-2147483648.5), 1'b0, 1'b0, N_IND, 1'b0, 1'b1, "R8 -2^31-0.5");

        // R2 mode selection
        send($realtobits(2147483648.0), 1'b1, 1'b0, N_IND, 1'b1, 1'b0, "R2 long only");
        send($realtobits(2147483648.0), 1'b0, 1'b1, N_IND, 1'b1, 1'b0, "R2 wide only");
        send($realtobits(2147483648.0), 1'b1, 1'b1, 64'h0000_0000_8000_0000, 1'b0, 1'b0, "R2 both");
        send($realtobits(-1.0), 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, "R2 R9 -1 narrow");
        send($realtobits(-5.5), 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 1'b0, 1'b1, "R2 -5.5 wide");
        gap_check("R10 gap 2");

        // R4 wide range edges and shift direction boundaries
        send(64'h43E0_0000_0000_0000, 1'b1, 1'b1, W_IND, 1'b1, 1'b0, "R4 2^63");
        send(64'h43DF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'h7FFF_FFFF_FFFF_FC00, 1'b0, 1'b0, "R4 below 2^63");
        send($realtobits(1.0e300), 1'b1, 1'b1, W_IND, 1'b1, 1'b0, "R4 1e300");
        send(64'hC3E0_0000_0000_0000, 1'b1, 1'b1, W_IND, 1'b0, 1'b0, "R8 -2^63");
        send(64'h4330_0000_0000_0001, 1'b1, 1'b1, 64'h0010_0000_0000_0001, 1'b0, 1'b0, "R1 2^52+1");
        send(64'h4348_0000_0000_0000, 1'b1, 1'b1, 64'h0030_0000_0000_0000, 1'b0, 1'b0, "R1 1.5*2^53");

        // R5 special encodings
        send(64'h7FF8_0000_0000_0000, 1'b0, 1'b0, N_IND, 1'b1, 1'b0, "R5 qNaN narrow");
        send(64'h7FF0_0000_0000_0001, 1'b1, 1'b1, W_IND, 1'b1, 1'b0, "R5 sNaN wide");
        send(64'h7FF0_0000_0000_0000, 1'b0, 1'b0, N_IND, 1'b1, 1'b0, "R5 +inf narrow");
        send(64'hFFF0_0000_0000_0000, 1'b1, 1'b1, W_IND, 1'b1, 1'b0, "R5 -inf wide");

        // R7 R6 sub-unit magnitudes
        send(64'h0000_0000_0000_0000, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, "R7 +0");
        send(64'h8000_0000_0000_0000, 1'b1, 1'b1, 64'h0, 1'b0, 1'b0, "R7 -0");
        send(64'h0000_0000_0000_0001, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, "R7 denormal");
        send($realtobits(0.999), 1'b1, 1'b1, 64'h0, 1'b0, 1'b1, "R6 0.999");
        send($realtobits(-0.5), 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, "R7 -0.5");

        gap_check("R10 drain");
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing results: %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule